// File: doc/BRIEF.md
# Fractional Frequency Offset Calculator

This block turns a base frequency and a target frequency, both given in whole hertz, into a signed 24-bit fine-tune word for an oscillator's fine-adjust loop. One step of the word is 0.0001164 ppm of the base frequency. The word therefore equals the exact ratio (1e6 / 0.0001164) · (target − base) / base to within one step. A zero word leaves the oscillator at the base frequency.

Both frequencies are presented together with a one-cycle start strobe. The block takes the magnitude of the difference and scales it by the integer constant 8591065292. It then divides the scaled value by the base frequency in a sequential restoring divider that retires one quotient bit per clock. The sign is put back at the end. A quotient too large for the 24-bit field is clamped to the largest magnitude the field holds, and a flag reports the clamp. A base frequency of zero is refused at once with an error flag, and no division is done.

Top module: `freq_offset_calc`

## Requirements
- R1: After synchronous reset, word_o is 0 and done_o, sat_o and err_o are all 0.
- R2: When target ≥ base > 0 and the quotient fits, word_o = floor(8591065292 · (target − base) / base) in 24-bit two's complement, and sat_o = 0.
- R3: When target < base, word_o is the two's complement negation of floor(8591065292 · (base − target) / base), so the result is truncated toward zero.
- R4: When target equals base, word_o is 0 and sat_o is 0.
- R5: When the positive quotient magnitude exceeds 8388607 (2^23 − 1), word_o = 24'h7FFFFF and sat_o = 1.
- R6: When the negative quotient magnitude exceeds 8388607, word_o = 24'h800001 (−8388607) and sat_o = 1.
- R7: A start with base equal to 0 gives err_o = 1, word_o = 0 and sat_o = 0, and done_o is high in the cycle right after the accepting edge.
- R8: For a nonzero base, done_o is a single-cycle pulse that is visible after the 67th rising edge following the edge that accepted start (66 divide steps plus one output register).
- R9: A start pulse that arrives while a division is in progress is ignored. It changes neither the result nor the number of done pulses.
- R10: word_o, sat_o and err_o hold their values between done pulses, and every new result replaces all three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to compute; sampled only when idle |
| base_hz_i | input | 32 | Base frequency in Hz, unsigned |
| target_hz_i | input | 32 | Target frequency in Hz, unsigned |
| word_o | output | 24 | Signed offset word in 0.0001164 ppm steps |
| sat_o | output | 1 | Result was clamped to the field limit |
| err_o | output | 1 | Request refused because the base was zero |
| done_o | output | 1 | One-cycle pulse when a new result is on the outputs |

## Verification
The embedded assertions check on every cycle that a saturated word holds only one of the two clamp codes, that an error result carries a zero word and no clamp flag, that done never coincides with a running division, that the divider is never reloaded mid-run, and that its finish strobe lasts one cycle. Arithmetic correctness, truncation toward zero, the exact position of the saturation threshold, the 67-cycle latency and the rejection of a start pulse during a division can only be shown by the scenarios. In those scenarios the bench compares each result against wide-integer expected values computed from the formula.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  localparam int unsigned FREQ_W  = 32;
  localparam int unsigned WORD_W  = 24;
  localparam int unsigned SCALE_W = 34;
  // steps per unit ratio: round(1e6 / 0.0001164), held as an integer
  localparam logic [SCALE_W-1:0] SCALE_K = 34'd8591065292;
endpackage

// File: rtl/ofc_scale.sv
module ofc_scale #(
  parameter int unsigned FW = 32,
  parameter int unsigned KW = 34,
  parameter int unsigned DW = FW + KW,
  parameter logic [KW-1:0] K = '0
) (
  input  logic [FW-1:0] base_hz,
  input  logic [FW-1:0] target_hz,
  output logic          neg,
  output logic          base_zero,
  output logic [DW-1:0] scaled
);
  logic [FW-1:0] mag;

  always_comb begin
    neg       = target_hz < base_hz;
    mag       = neg ? (base_hz - target_hz) : (target_hz - base_hz);
    base_zero = (base_hz == '0);
    scaled    = DW'(K) * DW'(mag);
  end
endmodule

// File: rtl/ofc_divider.sv
module ofc_divider #(
  parameter int unsigned DW = 66,
  parameter int unsigned VW = 32,
  localparam int unsigned CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          fin,
  output logic [DW-1:0] quot
);
  logic [DW-1:0] acc_q;
  logic [VW-1:0] rem_q;
  logic [VW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          fin_q;
  logic [VW:0]   trial;
  logic          fits;
  logic [VW-1:0] rem_n;

  always_comb begin
    trial = {rem_q, acc_q[DW-1]};
    fits  = trial >= {1'b0, dvs_q};
    rem_n = fits ? VW'(trial - {1'b0, dvs_q}) : trial[VW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load) begin
        acc_q  <= dividend;
        rem_q  <= '0;
        dvs_q  <= divisor;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= {acc_q[DW-2:0], fits};
        rem_q <= rem_n;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(DW - 1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign fin  = fin_q;
  assign quot = acc_q;

  // R9: the controller must never reload the divider during a run
  a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !load);

  // R8: the finish strobe lasts exactly one cycle
  a_r8_fin_pulse: assert property (@(posedge clk) disable iff (rst)
    fin_q |=> !fin_q);
endmodule

// File: rtl/ofc_clamp.sv
module ofc_clamp #(
  parameter int unsigned DW = 66,
  parameter int unsigned WW = 24
) (
  input  logic [DW-1:0] quot,
  input  logic          neg,
  output logic [WW-1:0] word,
  output logic          sat
);
  localparam logic [DW-1:0] QMAX = {{(DW-WW+1){1'b0}}, {(WW-1){1'b1}}};
  localparam logic [WW-1:0] MMAX = {1'b0, {(WW-1){1'b1}}};
  logic [WW-1:0] mag;

  always_comb begin
    sat  = quot > QMAX;
    mag  = sat ? MMAX : quot[WW-1:0];
    word = neg ? (~mag + 1'b1) : mag;
  end
endmodule

// File: rtl/freq_offset_calc.sv
module freq_offset_calc #(
  parameter int unsigned FW = ofc_pkg::FREQ_W,
  parameter int unsigned WW = ofc_pkg::WORD_W,
  parameter int unsigned KW = ofc_pkg::SCALE_W,
  parameter logic [KW-1:0] K = ofc_pkg::SCALE_K
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [FW-1:0] base_hz_i,
  input  logic [FW-1:0] target_hz_i,
  output logic [WW-1:0] word_o,
  output logic          sat_o,
  output logic          err_o,
  output logic          done_o
);
  localparam int unsigned DW = FW + KW;
  localparam logic [WW-1:0] POS_LIM = {1'b0, {(WW-1){1'b1}}};
  localparam logic [WW-1:0] NEG_LIM = {1'b1, {(WW-2){1'b0}}, 1'b1};

  logic          neg_c, zero_c;
  logic [DW-1:0] scaled_c;
  logic          accept, load;
  logic          busy_q, neg_q;
  logic          div_fin;
  logic [DW-1:0] div_quot;
  logic [WW-1:0] cl_word;
  logic          cl_sat;

  ofc_scale #(.FW(FW), .KW(KW), .DW(DW), .K(K)) scale_i (
    .base_hz(base_hz_i), .target_hz(target_hz_i),
    .neg(neg_c), .base_zero(zero_c), .scaled(scaled_c)
  );

  assign accept = start_i && !busy_q;
  assign load   = accept && !zero_c;

  ofc_divider #(.DW(DW), .VW(FW)) div_i (
    .clk(clk), .rst(rst), .load(load),
    .dividend(scaled_c), .divisor(base_hz_i),
    .fin(div_fin), .quot(div_quot)
  );

  ofc_clamp #(.DW(DW), .WW(WW)) clamp_i (
    .quot(div_quot), .neg(neg_q), .word(cl_word), .sat(cl_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      word_o <= '0;
      sat_o  <= 1'b0;
      err_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept && zero_c) begin
        word_o <= '0;
        sat_o  <= 1'b0;
        err_o  <= 1'b1;
        done_o <= 1'b1;
      end
      if (load) begin
        busy_q <= 1'b1;
        neg_q  <= neg_c;
      end
      if (div_fin) begin
        busy_q <= 1'b0;
        word_o <= cl_word;
        sat_o  <= cl_sat;
        err_o  <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  // R5 / R6: a clamped word carries one of the two limit codes
  a_r5_sat_code: assert property (@(posedge clk) disable iff (rst)
    sat_o |-> (word_o == POS_LIM || word_o == NEG_LIM));

  // R7: a refused request reports a clean zero word
  a_r7_err_clean: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (word_o == '0 && !sat_o));

  // R8: a result is never announced while a division still runs
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_q);
endmodule

// File: tb/freq_offset_calc_tb_top.sv
module freq_offset_calc_tb_top;
  localparam longint unsigned KCONST = 64'd8591065292;
  localparam int LAT_DIV = 67;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] base_hz_i = '0;
  logic [31:0] target_hz_i = '0;
  logic [23:0] word_o;
  logic        sat_o, err_o, done_o;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  logic [23:0] last_word;

  typedef struct {
    logic [23:0] word;
    logic        sat;
    logic        err;
    int          st;
    int          lat;
    string       req;
  } exp_t;
  exp_t sb[$];

  freq_offset_calc dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .base_hz_i(base_hz_i), .target_hz_i(target_hz_i),
    .word_o(word_o), .sat_o(sat_o), .err_o(err_o), .done_o(done_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] b, input logic [31:0] t,
                                 input string req);
    exp_t e;
    logic [127:0] mag, q;
    logic [23:0] m;
    e.req = req;
    e.st = 0;
    if (b == 0) begin
      e.word = '0; e.sat = 1'b0; e.err = 1'b1; e.lat = 0;
      return e;
    end
    mag = (t >= b) ? 128'(t - b) : 128'(b - t);
    q = (128'(KCONST) * mag) / 128'(b);
    e.err = 1'b0;
    e.lat = LAT_DIV;
    if (q > 128'd8388607) begin
      m = 24'h7FFFFF; e.sat = 1'b1;
    end else begin
      m = q[23:0]; e.sat = 1'b0;
    end
    e.word = (t < b) ? (~m + 24'd1) : m;
    return e;
  endfunction

  // monitor: pops and compares as each result appears
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(word_o == e.word, e.req, "word", longint'(word_o), longint'(e.word));
        chk(sat_o == e.sat, e.req, "sat", longint'(sat_o), longint'(e.sat));
        chk(err_o == e.err, e.req, "err", longint'(err_o), longint'(e.err));
        chk((cyc - e.st) == e.lat, "R8", "latency", longint'(cyc - e.st), longint'(e.lat));
        last_word = word_o;
      end
    end
  end

  task automatic issue(input logic [31:0] b, input logic [31:0] t, input string req);
    exp_t e;
    @(negedge clk);
    base_hz_i = b;
    target_hz_i = t;
    start_i = 1'b1;
    e = model(b, t, req);
    e.st = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_op(input logic [31:0] b, input logic [31:0] t, input string req);
    issue(b, t, req);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lf = 32'h1234_5678;
    logic [127:0] edge_d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(word_o == 0, "R1", "word", longint'(word_o), 0);
    chk(!done_o && !sat_o && !err_o, "R1", "flags",
        longint'({done_o, sat_o, err_o}), 0);

    run_op(32'd10_000_000, 32'd10_000_100, "R2");
    run_op(32'd7_150_000, 32'd7_155_000, "R2");
    run_op(32'd7_150_000, 32'd7_145_000, "R3");
    run_op(32'd123_456_789, 32'd123_456_788, "R3");
    run_op(32'd50_000_000, 32'd50_000_000, "R4");
    run_op(32'd1000, 32'd2000, "R5");
    run_op(32'hFFFF_FFFF, 32'd0, "R6");
    run_op(32'd1000, 32'd0, "R6");
    run_op(32'd0, 32'd5000, "R7");
    run_op(32'd1, 32'd1, "R4");

    // saturation threshold with the largest base
    edge_d = (128'd8388607 * 128'hFFFF_FFFF) / 128'(KCONST);
    run_op(32'hFFFF_FFFF - 32'(edge_d), 32'hFFFF_FFFF, "R5");
    run_op(32'hF000_0000, 32'hF000_0000 + 32'(edge_d), "R5");
    run_op(32'hF000_0000, 32'hF000_0000 + 32'(edge_d) + 32'd1, "R5");
    run_op(32'hF000_0000, 32'hF000_0000 - 32'(edge_d) - 32'd1, "R6");

    // several pseudo-random small offsets
    for (int i = 0; i < 8; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_op({4'h1, lf[27:0]}, {4'h1, lf[27:0]} + {{20{lf[31]}}, lf[11:0]},
             lf[31] ? "R3" : "R2");
    end

    // R9: a second start during the division must be ignored
    issue(32'd20_000_000, 32'd20_010_000, "R9");
    repeat (5) @(negedge clk);
    base_hz_i = 32'd0;
    target_hz_i = 32'd99;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    chk(sb.size() == 0 && !done_o, "R9", "no extra result", longint'(done_o), 0);

    // R10: outputs hold between results
    run_op(32'd9_000_000, 32'd8_999_000, "R10");
    repeat (10) @(negedge clk);
    chk(word_o == last_word, "R10", "word held", longint'(word_o), longint'(last_word));
    chk(!done_o && !err_o, "R10", "flags held", longint'({done_o, err_o}), 0);
    run_op(32'd0, 32'd1, "R10");
    run_op(32'd3000, 32'd9000, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule